// File: doc/BRIEF.md
# Three-Phase Complementary Dead-Time Generator

This block sits between a motor-control PWM timer and the gate drivers of a three-leg inverter. It takes one PWM phase signal per leg. For each leg it drives a high-side output and a low-side output. After every edge of a phase, both outputs of that leg stay low for a programmable guard interval. When the interval ends, the high side follows the phase and the low side follows its inverse. This keeps the two switches of one leg from ever conducting at the same time.

All three legs share one guard-length register. Each leg has its own counter. A leg's counter restarts on either edge of its phase and stops when it reaches the shared length. The counters advance only on the timer's prescaled count strobe, so the guard length is expressed in timer ticks rather than system clocks. A run-enable bit starts and stops the block. The guard-length register accepts writes only while the block is stopped.

Top module: `dtg_top`

## Requirements
- R1: After reset the guard length is zero and all six outputs are low.
- R2: A write to the guard-length register takes effect on the next clock only while `run_en` is low. A write while `run_en` is high is ignored, and the guard length observed at the outputs is unchanged.
- R3: With a guard length of zero and `run_en` high, `hs_out[i]` equals `pwm_in[i]` one clock later and `ls_out[i]` equals its inverse, with no gap.
- R4: With a guard length of N ≥ 1, after every edge of `pwm_in[i]` both outputs of leg i are low until N `cnt_tick` pulses have occurred after the edge clock. From the clock of the N-th tick onward, the outputs follow the phase as in R3.
- R5: A leg's guard counter advances only in clocks where `cnt_tick` is high. A tick in the same clock as the edge is not counted.
- R6: An edge of `pwm_in[i]` that arrives during an unfinished guard interval restarts that leg's interval from zero. Both of its outputs stay low throughout.
- R7: While `run_en` is low, all six outputs are low from the next clock, and no guard interval is in progress. Raising `run_en` lets the outputs follow the phases without an initial guard interval.
- R8: The three legs are independent. An edge on one phase does not change the outputs or counters of the other legs.
- R9: `hs_out[i]` and `ls_out[i]` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Prescaled count strobe from the timer |
| run_en | input | 1 | Run enable; low forces all outputs low and unlocks the register |
| dt_we | input | 1 | Guard-length write strobe |
| dt_wdata | input | CNT_W | Guard-length write data, in ticks |
| pwm_in | input | NPH | PWM phase inputs, one bit per leg |
| hs_out | output | NPH | High-side outputs, registered, active high |
| ls_out | output | NPH | Low-side outputs, registered, active high |

## Verification
The bench builds the block with `CNT_W` = 4 and the default three legs. This makes every guard length from 0 to the maximum of 15 reachable in a short run, and the full-scale match at the counter's top value is covered. Each length is swept with staggered phase periods that are longer than the guard. It is also swept with periods shorter than the guard, so that restarts are exercised. The count strobe is run both continuous and divided by three. Register writes are issued while stopped and while running. A cycle model in the bench works out the outputs from ticks counted since each edge.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   typedef enum logic {
      LEG_FOLLOW = 1'b0,
      LEG_GUARD  = 1'b1
   } leg_state_e;

   function automatic logic drive_high(input logic running, input leg_state_e st,
                                       input logic phase);
      return running && (st == LEG_FOLLOW) && phase;
   endfunction

   function automatic logic drive_low(input logic running, input leg_state_e st,
                                      input logic phase);
      return running && (st == LEG_FOLLOW) && !phase;
   endfunction

endpackage

// File: rtl/dtg_cfg_reg.sv
module dtg_cfg_reg #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] guard_len
);

   logic accept;
   assign accept = we && !run_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      guard_len <= '0;
      else if (accept) guard_len <= wdata;
   end

   assert_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(guard_len));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !run_en) |=> (guard_len == $past(wdata)));

endmodule

// File: rtl/dtg_leg.sv
module dtg_leg
   import dtg_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic             run_en,
   input  logic [CNT_W-1:0] guard_len,
   input  logic             phase,
   output logic             hs,
   output logic             ls
);

   localparam int EXT_W = CNT_W + 1;

   logic             phase_q;
   logic             edge_seen;
   leg_state_e       st, st_nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic [EXT_W-1:0] cnt_inc;
   logic             hit;

   assign edge_seen = phase ^ phase_q;
   assign cnt_inc   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
   assign hit       = (cnt_inc == {1'b0, guard_len});

   always_comb begin
      st_nxt  = st;
      cnt_nxt = cnt;
      if (!run_en) begin
         st_nxt  = LEG_FOLLOW;
         cnt_nxt = '0;
      end else if (edge_seen) begin
         cnt_nxt = '0;
         st_nxt  = (guard_len != '0) ? LEG_GUARD : LEG_FOLLOW;
      end else if (st == LEG_GUARD && cnt_tick) begin
         if (hit) begin
            cnt_nxt = '0;
            st_nxt  = LEG_FOLLOW;
         end else begin
            cnt_nxt = cnt_inc[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         st      <= LEG_FOLLOW;
         cnt     <= '0;
         hs      <= 1'b0;
         ls      <= 1'b0;
      end else begin
         phase_q <= phase;
         st      <= st_nxt;
         cnt     <= cnt_nxt;
         hs      <= drive_high(run_en, st_nxt, phase);
         ls      <= drive_low(run_en, st_nxt, phase);
      end
   end

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs && ls));

   assert_guard_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LEG_GUARD) |-> (!hs && !ls));

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LEG_GUARD) |-> (cnt < guard_len));

   assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !cnt_tick && !edge_seen && st == LEG_GUARD) |=> $stable(cnt));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && edge_seen && guard_len != '0) |=> (st == LEG_GUARD && cnt == '0));

   assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!hs && !ls && st == LEG_FOLLOW));

endmodule

// File: rtl/dtg_top.sv
module dtg_top #(
   parameter int NPH   = 3,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic             run_en,
   input  logic             dt_we,
   input  logic [CNT_W-1:0] dt_wdata,
   input  logic [NPH-1:0]   pwm_in,
   output logic [NPH-1:0]   hs_out,
   output logic [NPH-1:0]   ls_out
);

   generate
      if (NPH < 1 || NPH > 8) begin : g_bad_nph
         $error("dtg_top: NPH must lie in 1..8");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("dtg_top: CNT_W must lie in 1..16");
      end
   endgenerate

   logic [CNT_W-1:0] guard_len;

   dtg_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .we        (dt_we),
      .wdata     (dt_wdata),
      .guard_len (guard_len)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NPH; gi++) begin : g_leg
         dtg_leg #(.CNT_W(CNT_W)) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_tick  (cnt_tick),
            .run_en    (run_en),
            .guard_len (guard_len),
            .phase     (pwm_in[gi]),
            .hs        (hs_out[gi]),
            .ls        (ls_out[gi])
         );
      end
   endgenerate

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (hs_out == '0 && ls_out == '0));

endmodule

// File: tb/tb_dtg_top.sv
module tb_dtg_top;
   localparam int NPH   = 3;
   localparam int CNT_W = 4;
   localparam int BIG   = 1 << 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cnt_tick = 1'b0;
   logic             run_en = 1'b0;
   logic             dt_we = 1'b0;
   logic [CNT_W-1:0] dt_wdata = '0;
   logic [NPH-1:0]   pwm_in = '0;
   logic [NPH-1:0]   hs_out, ls_out;

   int    n_checks = 0;
   int    n_err    = 0;
   bit    done     = 0;
   bit    chk_en   = 0;
   string cur_req  = "R1";

   int              m_len = 0;
   int              m_tk [NPH];
   logic [NPH-1:0]  m_prev = '0;
   logic [NPH-1:0]  m_hs = '0, m_ls = '0;

   always #5 clk = ~clk;

   dtg_top #(.NPH(NPH), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .run_en(run_en),
      .dt_we(dt_we), .dt_wdata(dt_wdata), .pwm_in(pwm_in),
      .hs_out(hs_out), .ls_out(ls_out)
   );

   // Cycle model: outputs follow from ticks counted since each leg's last edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_len = 0; m_prev = '0; m_hs = '0; m_ls = '0;
         for (int i = 0; i < NPH; i++) m_tk[i] = BIG;
      end else begin
         for (int i = 0; i < NPH; i++) begin
            if (!run_en) begin
               m_tk[i] = BIG; m_hs[i] = 1'b0; m_ls[i] = 1'b0;
            end else begin
               if (pwm_in[i] != m_prev[i]) m_tk[i] = 0;
               else if (cnt_tick && m_tk[i] < BIG) m_tk[i] = m_tk[i] + 1;
               m_hs[i] = !(m_len != 0 && m_tk[i] < m_len) && pwm_in[i];
               m_ls[i] = !(m_len != 0 && m_tk[i] < m_len) && !pwm_in[i];
            end
         end
         m_prev = pwm_in;
         if (dt_we && !run_en) m_len = int'(dt_wdata);
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en && !done) begin
         check(cur_req, {26'd0, hs_out, ls_out}, {26'd0, m_hs, m_ls});
         check("R9", 32'(hs_out & ls_out), 32'd0);
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic write_len(input int v);
      dt_we = 1'b1; dt_wdata = CNT_W'(v); step(); dt_we = 1'b0; step();
   endtask

   // Drive phases with given half-periods; tick high every tdiv clocks.
   task automatic pattern(input int ncyc, input int p0, input int p1, input int p2,
                          input int tdiv);
      for (int c = 1; c <= ncyc; c++) begin
         cnt_tick = (c % tdiv) == 0;
         if (c % p0 == 0) pwm_in[0] = ~pwm_in[0];
         if (c % p1 == 0) pwm_in[1] = ~pwm_in[1];
         if (c % p2 == 0) pwm_in[2] = ~pwm_in[2];
         step();
      end
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_err++; n_checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      step();
      // R1: reset state at the ports
      check("R1", 32'({hs_out, ls_out}), 32'd0);
      chk_en = 1;
      // R3: reset length is zero, so outputs are pure complements
      cur_req = "R3";
      run_en = 1'b1;
      pattern(60, 3, 4, 5, 1);
      run_en = 1'b0; step();
      // R4 sweep over every length with continuous ticks; R8 via staggered legs
      for (int d = 0; d < (1 << CNT_W); d++) begin
         cur_req = "R4";
         write_len(d);
         run_en = 1'b1;
         pattern(6 * d + 40, d + 3, d + 5, 2 * d + 4, 1);
         cur_req = "R8";
         pattern(3 * d + 20, 2 * d + 7, 1000, 1000, 1);
         // R6: edges faster than the guard length
         cur_req = "R6";
         pattern(4 * d + 20, (d / 2) + 1, (d / 3) + 1, d + 1, 1);
         cur_req = "R7";
         run_en = 1'b0;
         pattern(6, 2, 3, 1, 1);
      end
      // R5: divided tick
      for (int d = 1; d < (1 << CNT_W); d += 3) begin
         cur_req = "R5";
         write_len(d);
         run_en = 1'b1;
         pattern(12 * d + 40, 3 * d + 5, 3 * d + 7, 4 * d + 2, 3);
         run_en = 1'b0; step();
      end
      // R2: write while running is ignored
      cur_req = "R2";
      write_len(5);
      run_en = 1'b1; step();
      dt_we = 1'b1; dt_wdata = CNT_W'(12); step(); dt_we = 1'b0;
      pattern(80, 9, 11, 13, 1);
      run_en = 1'b0; step();
      write_len(12);
      run_en = 1'b1;
      pattern(80, 17, 19, 23, 1);
      // R7: stop mid-guard, then restart without a guard interval
      cur_req = "R7";
      pwm_in[0] = ~pwm_in[0]; step();
      run_en = 1'b0; step();
      check("R7", 32'({hs_out, ls_out}), 32'd0);
      run_en = 1'b1;
      pattern(30, 40, 40, 40, 1);
      step();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule